// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a register-to-register synchronous SRAM with a four-beat burst counter. Each word is 18 bits wide and split into two 9-bit lanes. An access is opened by one of two active-low strobes: a processor-side strobe that always opens a read, and a controller-side strobe that opens a read or a write depending on the write controls it sees. After the opening edge, an advance input steps a 2-bit counter. The counter walks the word address inside its aligned group of four, in either linear or interleaved order.

Writes use a global write input that stores the whole word, or a lane-write enable together with one strobe per lane. Read data passes through an internal access register and then a data-out register, so it is valid on the second clock edge after the access edge. The output carries a valid flag instead of a three-state bus. The read path has no back-pressure: a consumer must take `dout` in every cycle where `dout_vld` is high, because the memory never stalls. Three chip selects gate new cycles. The first select also masks the processor strobe but does not mask the controller strobe.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, `dout_vld` is low, and no access takes place until a strobe opens a cycle with all selects active (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0).
- R2: A processor-strobe edge (`proc_strb_n`=0 with `sel_a_n`=0) with all selects active loads `addr` and reads that word. Its data is on `dout` with `dout_vld` high after the second rising edge, provided `out_en_n` is low.
- R3: `adv_n` has no effect on the edge that opens a cycle, so the count restarts at 0. On later edges the count steps by one only when `adv_n`=0 and both strobes are high. Otherwise the same address is accessed again.
- R4: The two low address bits of an access are start^count when `order_ilv`=1, and (start+count) mod 4 when `order_ilv`=0. The upper bits stay those of the start address, so a burst wraps inside its group of four.
- R5: With `all_wr_n`=0 on a write edge, both lanes are written whatever `lane_strb_n` holds. Lane 0 is `din[8:0]` and lane 1 is `din[17:9]`.
- R6: With `all_wr_n`=1 and `lane_wr_en_n`=0, only the lanes whose `lane_strb_n` bit is 0 are written. With `lane_wr_en_n`=1, nothing is written.
- R7: On a processor-strobe edge the write controls are ignored and the access is a read. On the continuation edges that follow, lane writes go to the current burst address.
- R8: `dout_vld` is high only when a read result is pending and `out_en_n` is low. It is low for the whole cycle after any edge that performed a write.
- R9: The controller strobe opens a cycle only when the processor strobe is high or masked by `sel_a_n`. The write controls on that edge choose between a write at `addr` and a read.
- R10: With `sel_a_n`=1, the processor strobe is masked: no cycle opens, and the open burst continues without advancing. A controller-strobe edge with any select inactive closes the burst.
- R11: A processor-strobe edge with `sel_a_n`=0 but `sel_b` or `sel_c_n` inactive closes the burst, and no access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address loaded when a cycle opens |
| din | input | LANE_W*LANES | Write data, lane g in bits [g*LANE_W +: LANE_W] |
| proc_strb_n | input | 1 | Processor strobe, active low, opens a read |
| ctrl_strb_n | input | 1 | Controller strobe, active low, opens a read or write |
| adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | First chip select, active low, also masks the processor strobe |
| sel_b | input | 1 | Second chip select, active high |
| sel_c_n | input | 1 | Third chip select, active low |
| order_ilv | input | 1 | 1 = interleaved burst order, 0 = linear |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Lane-write enable, active low |
| lane_strb_n | input | LANES | Per-lane write strobes, active low |
| out_en_n | input | 1 | Output enable, active low |
| dout | output | LANE_W*LANES | Registered read data |
| dout_vld | output | 1 | Read data valid (drive enable) |

## Verification
The properties assume that every control input is a known 0 or 1 at each rising edge and that data is only checked for words that have been written. The bench therefore fills the whole array through controller-strobe writes before it reads anything. It drives inputs only on falling edges and never leaves a control input undriven. The random phase keeps the selects active most of the time and lets the order select change freely, because the group-wrap property holds under either order. `out_en_n` acts without a register, so the bench compares the valid flag against the value of `out_en_n` in the same cycle.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  // Kind of array access decided on a clock edge
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_e;
endpackage

// File: rtl/sbsram_burst_ctrl.sv
// Strobe arbitration, address register and burst counter.
module sbsram_burst_ctrl #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CNT_W  = 2   // must be below ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_strb_n,
  input  logic              ctrl_strb_n,
  input  logic              adv_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              order_ilv,
  output logic              go_o,
  output logic              proc_start_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              active_o
);
  logic              sel_ok, proc_take, ctrl_take, start, step;
  logic [CNT_W-1:0]  cnt_q, cnt_nx, low;
  logic [ADDR_W-1:0] base_q;
  logic              active_q;

  always_comb begin
    sel_ok    = !sel_a_n && sel_b && !sel_c_n;
    proc_take = !proc_strb_n && !sel_a_n;          // first select masks it
    ctrl_take = !ctrl_strb_n && !proc_take;        // processor strobe wins
    start     = proc_take || ctrl_take;
    step      = active_q && !adv_n && proc_strb_n && ctrl_strb_n;
    cnt_nx    = step ? cnt_q + 1'b1 : cnt_q;
    low       = order_ilv ? (base_q[CNT_W-1:0] ^ cnt_nx)
                          : (base_q[CNT_W-1:0] + cnt_nx);
    acc_addr_o   = start ? addr_i : {base_q[ADDR_W-1:CNT_W], low};
    go_o         = start ? sel_ok : active_q;
    proc_start_o = proc_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= sel_ok;
      base_q   <= addr_i;
      cnt_q    <= '0;
    end else begin
      cnt_q    <= cnt_nx;
    end
  end

  assign base_o   = base_q;
  assign cnt_o    = cnt_q;
  assign active_o = active_q;
endmodule

// File: rtl/sbsram_lane_mask.sv
// Decodes global and per-lane write controls into a lane mask.
module sbsram_lane_mask #(
  parameter int unsigned LANES = 2
) (
  input  logic             all_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_strb_n,
  output logic [LANES-1:0] mask_o
);
  always_comb begin
    if (!all_wr_n)          mask_o = '1;
    else if (!lane_wr_en_n) mask_o = ~lane_strb_n;
    else                    mask_o = '0;
  end
endmodule

// File: rtl/sbsram_lane_array.sv
// Lane-split storage, access register and data-out register.
module sbsram_lane_array
  import sbsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  acc_e                    kind_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        lane_we_i,
  input  logic [LANE_W*LANES-1:0] din_i,
  output logic [LANE_W*LANES-1:0] dout_o,
  output logic                    rd_vld_o,
  output logic                    wr_hiz_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] acc_addr_q;
  logic              acc_rd_q, rd_vld_q, wr_hiz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_addr_q <= '0;
      acc_rd_q   <= 1'b0;
      rd_vld_q   <= 1'b0;
      wr_hiz_q   <= 1'b0;
    end else begin
      acc_addr_q <= addr_i;
      acc_rd_q   <= (kind_i == ACC_RD);
      rd_vld_q   <= acc_rd_q;
      wr_hiz_q   <= (kind_i == ACC_WR);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    logic [LANE_W-1:0] out_q;
    always_ff @(posedge clk) begin
      if (lane_we_i[g]) mem_q[addr_i] <= din_i[g*LANE_W +: LANE_W];
      if (acc_rd_q)     out_q <= mem_q[acc_addr_q];
    end
    assign dout_o[g*LANE_W +: LANE_W] = out_q;
  end

  assign rd_vld_o = rd_vld_q;
  assign wr_hiz_o = wr_hiz_q;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2,
  parameter int unsigned BURST  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANE_W*LANES-1:0] din,
  input  logic                    proc_strb_n,
  input  logic                    ctrl_strb_n,
  input  logic                    adv_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    order_ilv,
  input  logic                    all_wr_n,
  input  logic                    lane_wr_en_n,
  input  logic [LANES-1:0]        lane_strb_n,
  input  logic                    out_en_n,
  output logic [LANE_W*LANES-1:0] dout,
  output logic                    dout_vld
);
  localparam int unsigned CNT_W = $clog2(BURST);

  logic              go, proc_start, burst_active, rd_vld, wr_hiz;
  logic [ADDR_W-1:0] acc_addr, base_addr;
  logic [CNT_W-1:0]  burst_cnt;
  logic [LANES-1:0]  wr_mask, lane_we;
  acc_e              acc_kind;

  sbsram_burst_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_i(addr),
    .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .order_ilv(order_ilv),
    .go_o(go), .proc_start_o(proc_start), .acc_addr_o(acc_addr),
    .base_o(base_addr), .cnt_o(burst_cnt), .active_o(burst_active)
  );

  sbsram_lane_mask #(.LANES(LANES)) u_mask (
    .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_strb_n(lane_strb_n), .mask_o(wr_mask)
  );

  // Write controls count only on accesses not opened by the processor strobe
  always_comb begin
    lane_we  = (go && !proc_start) ? wr_mask : '0;
    acc_kind = !go ? ACC_NONE : ((|lane_we) ? ACC_WR : ACC_RD);
  end

  sbsram_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk(clk), .rst_n(rst_n), .kind_i(acc_kind), .addr_i(acc_addr),
    .lane_we_i(lane_we), .din_i(din), .dout_o(dout),
    .rd_vld_o(rd_vld), .wr_hiz_o(wr_hiz)
  );

  assign dout_vld = rd_vld && !out_en_n && !wr_hiz;
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CNT_W  = 2,
  parameter int unsigned LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_strb_n,
  input logic              ctrl_strb_n,
  input logic              adv_n,
  input logic              out_en_n,
  input logic              dout_vld,
  input logic              go,
  input logic              proc_start,
  input logic              burst_active,
  input logic              rd_vld,
  input logic [LANES-1:0]  lane_we,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [ADDR_W-1:0] base_addr,
  input logic [CNT_W-1:0]  burst_cnt
);
  // R8: output driven only with the enable low
  assert_drive_needs_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |-> !out_en_n);

  // R8: a write edge blanks the following cycle
  assert_write_blanks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_we) |=> !dout_vld);

  // R7: processor-strobe edge never writes
  assert_proc_edge_reads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    proc_start |-> (lane_we == '0));

  // R3: advance ignored on the opening edge
  assert_count_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_start && go) |=> (burst_cnt == '0));

  // R3: no step without advance
  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && adv_n && proc_strb_n && ctrl_strb_n) |=> $stable(burst_cnt));

  // R4: continuation stays inside the aligned group
  assert_group_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && proc_strb_n && ctrl_strb_n) |->
      (acc_addr[ADDR_W-1:CNT_W] == base_addr[ADDR_W-1:CNT_W]));

  // R2: a read access yields a pending result two edges later
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (lane_we == '0)) |=> ##1 rd_vld);
endmodule

bind sync_burst_sram sync_burst_sram_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LANES(LANES)
) i_chk (
  .clk(clk), .rst_n(rst_n), .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n),
  .adv_n(adv_n), .out_en_n(out_en_n), .dout_vld(dout_vld), .go(go),
  .proc_start(proc_start), .burst_active(burst_active), .rd_vld(rd_vld),
  .lane_we(lane_we), .acc_addr(acc_addr), .base_addr(base_addr), .burst_cnt(burst_cnt)
);

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] ad = '0;
  logic [DW-1:0] di = '0;
  logic ps_n = 1, cs_n = 1, av_n = 1, ea_n = 0, eb = 1, ec_n = 0, ilv = 0;
  logic gw_n = 1, lw_n = 1, oe_n = 0;
  logic [1:0] ls_n = 2'b11;
  logic [DW-1:0] dout;
  logic dout_vld;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_sram i_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(ad), .din(di),
    .proc_strb_n(ps_n), .ctrl_strb_n(cs_n), .adv_n(av_n),
    .sel_a_n(ea_n), .sel_b(eb), .sel_c_n(ec_n), .order_ilv(ilv),
    .all_wr_n(gw_n), .lane_wr_en_n(lw_n), .lane_strb_n(ls_n),
    .out_en_n(oe_n), .dout(dout), .dout_vld(dout_vld)
  );

  // ---------------- behavioural reference ----------------
  logic [DW-1:0] m_mem [1<<AW];
  logic [AW-1:0] m_base, m_acc_a;
  logic [1:0]    m_cnt;
  bit m_live, m_acc_rd, m_rdv, m_hiz;
  logic [DW-1:0] m_dout;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_live = 0; m_acc_rd = 0; m_rdv = 0; m_hiz = 0; m_cnt = 0; m_base = 0; m_acc_a = 0;
    end else begin
      bit pt, ct, sel, acc, w0, w1;
      logic [AW-1:0] a;
      logic [1:0] lo;
      m_rdv  = m_acc_rd;
      if (m_acc_rd) m_dout = m_mem[m_acc_a];
      pt  = !ps_n && !ea_n;
      ct  = !cs_n && !pt;
      sel = !ea_n && eb && !ec_n;
      a   = ad;
      if (pt || ct) begin
        acc = sel;
        m_live = sel; m_base = ad; m_cnt = 0;
      end else begin
        acc = m_live;
        if (m_live && !av_n && ps_n && cs_n) m_cnt = m_cnt + 2'd1;
        lo = ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        a  = {m_base[AW-1:2], lo};
      end
      w0 = !gw_n || (!lw_n && !ls_n[0]);
      w1 = !gw_n || (!lw_n && !ls_n[1]);
      m_hiz = 0;
      if (acc && !pt && (w0 || w1)) begin
        if (w0) m_mem[a][8:0]  = di[8:0];
        if (w1) m_mem[a][17:9] = di[17:9];
        m_acc_rd = 0; m_hiz = 1;
      end else begin
        m_acc_rd = acc;
      end
      m_acc_a = a;
    end
  end

  // ---------------- per-cycle comparison ----------------
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && !done) begin
        bit ev;
        ev = m_rdv && !oe_n && !m_hiz;
        checks++;
        if (dout_vld !== ev) begin
          fails++;
          $display("FAIL %s: dout_vld=%b expected %b at %0t", tag, dout_vld, ev, $time);
        end else if (ev) begin
          checks++;
          if (dout !== m_dout) begin
            fails++;
            $display("FAIL %s: dout=%h expected %h at %0t", tag, dout, m_dout, $time);
          end
        end
      end
    end
  end

  task automatic idle();
    ps_n = 1; cs_n = 1; av_n = 1; ea_n = 0; eb = 1; ec_n = 0;
    gw_n = 1; lw_n = 1; ls_n = 2'b11; oe_n = 0; di = '0;
  endtask

  task automatic step();
    @(negedge clk); idle();
  endtask

  task automatic check_word(input logic [DW-1:0] exp, input string r);
    @(negedge clk); #3;
    checks++;
    if (dout_vld !== 1'b1 || dout !== exp) begin
      fails++;
      $display("FAIL %s: vld=%b dout=%h expected vld=1 dout=%h", r, dout_vld, dout, exp);
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #3;
    checks++;   // R1 reset state
    if (dout_vld !== 1'b0) begin
      fails++; $display("FAIL R1: dout_vld=%b expected 0 after reset", dout_vld);
    end
    // R1: advance with no open cycle produces nothing
    for (int i = 0; i < 4; i++) begin step(); av_n = 0; end

    // R9: fill the array through controller-strobe writes
    tag = "R9";
    for (int i = 0; i < (1<<AW); i++) begin
      step(); cs_n = 0; ad = AW'(i); gw_n = 0; di = DW'(i * 1031 + 7);
    end

    // R5: global write burst, strobes held high
    tag = "R5";
    step(); cs_n = 0; ad = 8; gw_n = 0; ls_n = 2'b11; di = 18'h11111;
    for (int i = 1; i < 4; i++) begin step(); av_n = 0; gw_n = 0; di = DW'(18'h22222 * i); end

    // R4/R3: linear read burst from 9, advance on opening edge ignored
    tag = "R4";
    step(); ps_n = 0; ad = 9; ilv = 0; av_n = 0;
    for (int i = 0; i < 6; i++) begin step(); av_n = 0; end
    tag = "R3";
    for (int i = 0; i < 3; i++) step();
    // R4: interleaved read burst from 22
    tag = "R4";
    step(); ps_n = 0; ad = 22; ilv = 1;
    for (int i = 0; i < 5; i++) begin step(); ilv = 1; av_n = 0; end

    // R10: masked processor strobe leaves burst open, no step
    tag = "R10";
    step(); ps_n = 0; ad = 30;
    step(); ps_n = 0; ea_n = 1; av_n = 0; ad = 3;
    step(); av_n = 0;
    step(); cs_n = 0; ec_n = 1; ad = 12;   // closes burst
    for (int i = 0; i < 3; i++) begin step(); av_n = 0; end

    // R6: lane writes
    tag = "R6";
    step(); cs_n = 0; ad = 40; gw_n = 0; di = 18'h3FFFF;
    step(); lw_n = 0; ls_n = 2'b10; di = 18'h00000;        // lane 0 only
    step(); lw_n = 1; ls_n = 2'b00; di = 18'h00000;        // no lane enable
    step(); ps_n = 0; ad = 40;
    step();
    check_word(18'h3FE00, "R6");

    // R7: processor edge ignores writes, continuation writes lane 1
    tag = "R7";
    step(); ps_n = 0; ad = 44; gw_n = 0; lw_n = 0; ls_n = 2'b00; di = 18'h0;
    step(); lw_n = 0; ls_n = 2'b01; av_n = 0; di = 18'h15555;
    step(); ps_n = 0; ad = 45;
    step();
    check_word({9'h0AA, 9'(45 * 1031 + 7)}, "R7");

    // R8: output enable high hides data
    tag = "R8";
    for (int i = 0; i < 4; i++) begin step(); oe_n = 1'(i % 2); end

    // R9: both strobes low, processor wins; writes ignored
    tag = "R9";
    step(); ps_n = 0; cs_n = 0; ad = 50; gw_n = 0; di = 18'h0;
    step();
    check_word(18'(50 * 1031 + 7), "R9");

    // R11: processor strobe with second select inactive closes
    tag = "R11";
    step(); ps_n = 0; eb = 0; ad = 2;
    for (int i = 0; i < 4; i++) begin step(); av_n = 0; gw_n = 0; end

    // R2: random mixed traffic
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      ps_n = ($urandom % 4) != 0;  cs_n = ($urandom % 5) != 0;
      av_n = 1'($urandom);         ea_n = ($urandom % 10) == 0;
      eb   = ($urandom % 10) != 0; ec_n = ($urandom % 10) == 0;
      ilv  = 1'($urandom);         gw_n = ($urandom % 4) != 0;
      lw_n = 1'($urandom);         ls_n = 2'($urandom);
      oe_n = ($urandom % 6) == 0;  ad = AW'($urandom); di = DW'($urandom);
    end
    step(); step(); step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule